// File: doc/BRIEF.md
# Shift Register with Parallel Load and Rotate

This block is a parameterized right-shifting register whose stages all share one clock. On every rising edge a single mode input picks the operation. One setting moves each bit one stage toward the output end and takes a new bit into the first stage. The other setting replaces every stage at once from a parallel data bus.

During a shift, a rotate-enable input picks where the first stage gets its new bit. With rotate enabled, the bit that leaves the last stage wraps around into the first stage. With rotate disabled, the first stage takes an external serial input pin.

The whole register is visible on a parallel output. The last stage drives a serial output. A synchronous active-high reset clears every stage and takes priority over both load and shift. The default width is four stages.

Top module: `shreg_ldrot`

## Requirements
- R1: While `rst` is high at a rising edge, every stage becomes 0 on that edge, whatever the values of `mode_ld`, `rot_en`, `ser_in` and `par_in`.
- R2: When `rst` is low and `mode_ld` is 1 at a rising edge, `q` equals `par_in` after that edge. The serial input and the rotate-enable input have no effect.
- R3: When `rst` is low, `mode_ld` is 0 and `rot_en` is 0 at a rising edge, the new value is `{ser_in, q[W-1:1]}`. Bit W-1 is the first stage and bit 0 is the last stage.
- R4: When `rst` is low, `mode_ld` is 0 and `rot_en` is 1 at a rising edge, the new value is `{q[0], q[W-1:1]}`. In this case `ser_in` has no effect.
- R5: `ser_out` always equals `q[0]`, the last stage.
- R6: With rotate enabled, W consecutive shift edges return the register to the value it held before them.
- R7: The register changes only at rising edges of `clk`, and all stages update on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all stages |
| rst | input | 1 | Synchronous reset, active high |
| mode_ld | input | 1 | 1 selects a parallel load, 0 selects a right shift |
| rot_en | input | 1 | During a shift, 1 wraps the last stage into the first stage |
| ser_in | input | 1 | Serial data into the first stage when rotate is off |
| par_in | input | W | Parallel load data |
| q | output | W | Contents of the register; bit W-1 is the first stage |
| ser_out | output | 1 | Value of the last stage |

## Verification
The assertions check on every cycle the result of reset, load, serial shift and rotate against the sampled inputs of the previous edge. They also check that the serial output tracks the last stage.

Some behaviour spans many edges, such as a full rotation returning the original word and a serial stream landing in the right bit order. Only the bench's sweeps show this. The bench applies every start value with every mode and every serial bit, and it runs complete rotation cycles.

// File: rtl/shreg_ldrot.sv
module shreg_ldrot #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_ld,
  input  logic         rot_en,
  input  logic         ser_in,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] q,
  output logic         ser_out
);
  logic         fill_bit;
  logic [W-1:0] shifted;

  assign fill_bit = rot_en ? q[0] : ser_in;
  assign shifted  = {fill_bit, q[W-1:1]};

  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (mode_ld) q <= par_in;
    else              q <= shifted;
  end

  assign ser_out = q[0];
endmodule

// File: rtl/shreg_ldrot_chk.sv
module shreg_ldrot_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         mode_ld,
  input logic         rot_en,
  input logic         ser_in,
  input logic [W-1:0] par_in,
  input logic [W-1:0] q,
  input logic         ser_out
);
  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= 1'b1;

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (q == '0)); // R1
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst) (primed && mode_ld) |=> (q == $past(par_in))); // R2
  AST_SHIFT_SERIAL: assert property (@(posedge clk) disable iff (rst) (primed && !mode_ld && !rot_en) |=> (q == {$past(ser_in), $past(q[W-1:1])})); // R3
  AST_SHIFT_ROTATE: assert property (@(posedge clk) disable iff (rst) (primed && !mode_ld && rot_en) |=> (q == {$past(q[0]), $past(q[W-1:1])})); // R4
  always_comb AST_SEROUT_LAST: assert (ser_out == q[0]); // R5
endmodule

bind shreg_ldrot shreg_ldrot_chk #(.W(W)) u_chk (.*);

// File: tb/shreg_ldrot_tb.sv
module shreg_ldrot_tb;
  localparam int W = 4;
  logic clk = 0, rst = 1, mode_ld = 0, rot_en = 0, ser_in = 0;
  logic [W-1:0] par_in = '0;
  logic [W-1:0] q;
  logic ser_out;
  int checks = 0, fails = 0;
  logic [W-1:0] model;

  always #10 clk = ~clk;

  shreg_ldrot #(.W(W)) u_dut (.*);

  task automatic chk(input string req, input logic [W-1:0] exp);
    checks++;
    if (q !== exp || ser_out !== exp[0]) begin
      fails++;
      $display("FAIL %s: q=%b ser_out=%b expected q=%b ser_out=%b", req, q, ser_out, exp, exp[0]);
    end
  endtask

  task automatic step(input logic r, input logic m, input logic ro, input logic s, input logic [W-1:0] p);
    rst = r; mode_ld = m; rot_en = ro; ser_in = s; par_in = p;
    @(posedge clk); #5;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(1, 1, 1, 1, '1);
    chk("R1 reset with load asserted", '0);
    for (int v = 0; v < (1 << W); v++) begin
      for (int op = 0; op < 6; op++) begin
        step(0, 1, op[0], op[1], v[W-1:0]);
        chk("R2 parallel load", v[W-1:0]);
        model = v[W-1:0];
        case (op)
          0, 1: begin step(0, 0, 0, op[0], ~v[W-1:0]); model = {op[0], model[W-1:1]}; chk("R3 serial shift", model); end
          2, 3: begin step(0, 0, 1, op[0], ~v[W-1:0]); model = {model[0], model[W-1:1]}; chk("R4 rotate ignores ser_in", model); end
          4:    begin step(1, 1, 0, 1, ~v[W-1:0]); chk("R1 reset over load", '0); end
          default: begin step(1, 0, 1, 1, v[W-1:0]); chk("R1 reset over shift", '0); end
        endcase
      end
      step(0, 1, 0, 0, v[W-1:0]);
      for (int k = 0; k < W; k++) step(0, 0, 1, ~v[k], '0);
      chk("R6 full rotation restores", v[W-1:0]);
    end
    step(0, 1, 0, 0, '0);
    for (int k = 0; k < W; k++) step(0, 0, 0, (k % 2 == 0), '1);
    chk("R3 serial stream order", 4'b0101);
    step(0, 1, 0, 0, 4'b1001);
    #3; par_in = 4'b0110; mode_ld = 0; #3;
    chk("R7 no change between edges", 4'b1001);
    @(posedge clk); #5;
    chk("R7 single edge shift", 4'b0100);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule